// File: doc/BRIEF.md
# Glitch-free master clock failover selector

This block chooses which of two clocks drives the internal master clock. One candidate is a free-running external oscillator clock. The other is the output of a PLL, which comes with a lock flag. A 2-bit mode field either fixes the choice on one source or lets the block decide by itself. In the automatic setting, the block falls back to the oscillator as soon as the PLL reports loss of lock. It returns to the PLL only after lock has held without a break for a programmable number of oscillator cycles.

Every change of source follows a break-before-make handshake. The enable for the source being left is dropped on that clock's falling edge. The enable for the new source is raised on its own falling edge, and only after the drop has crossed into its domain. As a result the output never carries a runt high pulse or a shortened low phase. The mode field and the force-lock bit are expected to change in the oscillator clock domain. The oscillator is assumed to run whenever the block is out of reset. A status flag reports which source is driving the output, and it is updated on rising edges of the output clock itself.

Top module: `mclk_failover_sel`

## Requirements
- R1: With `mode` = 2'b00 the output is driven by `clk_ext` whatever the lock flag does, and `src_is_pll` settles to 0.
- R2: With `mode` = 2'b01 the output is driven by `clk_pll` whatever the lock flag does, and `src_is_pll` settles to 1.
- R3: With `mode[1]` = 1 (automatic) and `lock_force` = 0, the lock flag passes through two `clk_ext` flip-flops. Once the synchronised flag is low, the next `clk_ext` edge selects the oscillator.
- R4: In automatic mode with `lock_force` = 0, the PLL is selected again only after the synchronised lock flag has stayed high for `HOLD_CYC` consecutive `clk_ext` cycles. Any drop during that window restarts the count from zero.
- R5: With `lock_force` = 1 in automatic mode, lock is treated as always present, so the PLL stays selected even while `pll_locked` is low.
- R6: The two source enables are never high together. Every high phase of `mclk_out` is a complete high phase of one source. No low phase of `mclk_out` is shorter than the shortest source half period.
- R7: `src_is_pll` is updated on each rising edge of `mclk_out`, taking the value 1 when the PLL is the driving source and 0 when the oscillator is.
- R8: While `rst_ext_n` and `rst_pll_n` are low, `mclk_out` is held low and `src_is_pll` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext | input | 1 | External oscillator clock, the failover source |
| rst_ext_n | input | 1 | Active-low asynchronous reset, clk_ext domain |
| clk_pll | input | 1 | PLL output clock |
| rst_pll_n | input | 1 | Active-low asynchronous reset, clk_pll domain |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| lock_force | input | 1 | 1: treat the PLL as locked at all times |
| mode | input | 2 | 00 fixed oscillator, 01 fixed PLL, 1x automatic |
| mclk_out | output | 1 | Selected master clock |
| src_is_pll | output | 1 | 1 when the PLL drives mclk_out |

## Verification
The bench cycles through the fixed modes while it toggles the lock flag. This separates a selector that honours the mode field from one that follows lock regardless of mode. In automatic mode it applies a clean loss and a clean return of lock, then a lock that chatters inside the hold window. The chatter separates a correct restart of the hold count from a count that keeps going or is skipped. A run with the force-lock bit set and lock held low shows that the override wins. A pulse-width monitor on the output checks every high and low phase across all of these switches, so a handshake that makes before it breaks shows up as a runt pulse.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic [1:0] {
    MODE_EXT  = 2'b00,
    MODE_PLL  = 2'b01,
    MODE_AUTO = 2'b10
  } mfs_mode_e;

  // Source decision: fixed modes ignore lock, automatic follows qualified lock.
  function automatic logic pick_pll(input logic [1:0] mode, input logic lock_ok);
    if (mode[1]) return lock_ok;
    return mode[0];
  endfunction
endpackage

// File: rtl/mfs_sync2.sv
module mfs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mfs_lock_qual.sv
module mfs_lock_qual #(
  parameter int HOLD_CYC = 64
) (
  input  logic clk_ext,
  input  logic rst_ext_n,
  input  logic pll_locked,
  input  logic lock_force,
  output logic lock_s,
  output logic lock_ok
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] hold_cnt;
  logic             hold_done;

  // R3: two-flop synchroniser into the oscillator domain
  mfs_sync2 u_lock_sync (
    .clk  (clk_ext),
    .rst_n(rst_ext_n),
    .d    (pll_locked),
    .q    (lock_s)
  );

  always_ff @(posedge clk_ext or negedge rst_ext_n) begin
    if (!rst_ext_n)            hold_cnt <= '0;
    else if (!lock_s)          hold_cnt <= '0;
    else if (hold_cnt != HOLD_V) hold_cnt <= hold_cnt + 1'b1;
  end

  assign hold_done = lock_s && (hold_cnt == HOLD_V);
  assign lock_ok   = lock_force || hold_done;

  // R4
  cnt_restart_chk: assert property (@(posedge clk_ext) disable iff (!rst_ext_n)
    !lock_s |=> (hold_cnt == '0));
  // R4
  cnt_bound_chk: assert property (@(posedge clk_ext) disable iff (!rst_ext_n)
    (hold_cnt == HOLD_V) && lock_s |=> (hold_cnt == HOLD_V));
endmodule

// File: rtl/mfs_gate_branch.sv
module mfs_gate_branch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en
);
  logic req_s;
  // first stage on the rising edge, enable changes on the falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_s <= 1'b0;
    else        req_s <= req;
  end
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= req_s;
  end
endmodule

// File: rtl/mclk_failover_sel.sv
module mclk_failover_sel #(
  parameter int HOLD_CYC = 64
) (
  input  logic       clk_ext,
  input  logic       rst_ext_n,
  input  logic       clk_pll,
  input  logic       rst_pll_n,
  input  logic       pll_locked,
  input  logic       lock_force,
  input  logic [1:0] mode,
  output logic       mclk_out,
  output logic       src_is_pll
);
  import mfs_pkg::*;

  logic lock_s, lock_ok;
  logic want_pll;
  logic en_ext, en_pll;
  logic req_ext, req_pll;

  mfs_lock_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk_ext   (clk_ext),
    .rst_ext_n (rst_ext_n),
    .pll_locked(pll_locked),
    .lock_force(lock_force),
    .lock_s    (lock_s),
    .lock_ok   (lock_ok)
  );

  always_ff @(posedge clk_ext or negedge rst_ext_n) begin
    if (!rst_ext_n) want_pll <= 1'b0;
    else            want_pll <= pick_pll(mode, lock_ok);
  end

  // break-before-make: each side may only request once the other is off
  assign req_ext = !want_pll && !en_pll;
  assign req_pll =  want_pll && !en_ext;

  mfs_gate_branch u_gate_ext (
    .clk  (clk_ext),
    .rst_n(rst_ext_n),
    .req  (req_ext),
    .en   (en_ext)
  );

  mfs_gate_branch u_gate_pll (
    .clk  (clk_pll),
    .rst_n(rst_pll_n),
    .req  (req_pll),
    .en   (en_pll)
  );

  assign mclk_out = (clk_ext && en_ext) || (clk_pll && en_pll);

  always_ff @(posedge mclk_out or negedge rst_ext_n) begin
    if (!rst_ext_n) src_is_pll <= 1'b0;
    else            src_is_pll <= en_pll;
  end

  // R6
  always_comb begin
    if (rst_ext_n && rst_pll_n) begin
      excl_enable_chk: assert (!(en_ext && en_pll));
    end
  end

  // R1
  fixed_ext_chk: assert property (@(posedge clk_ext) disable iff (!rst_ext_n)
    (mode == 2'b00) |=> !want_pll);
  // R2
  fixed_pll_chk: assert property (@(posedge clk_ext) disable iff (!rst_ext_n)
    (mode == 2'b01) |=> want_pll);
  // R3
  loss_fallback_chk: assert property (@(posedge clk_ext) disable iff (!rst_ext_n)
    (mode[1] && !lock_force && !lock_s) |=> !want_pll);
  // R5
  force_hold_chk: assert property (@(posedge clk_ext) disable iff (!rst_ext_n)
    (mode[1] && lock_force) |=> want_pll);
  // R7
  status_ext_chk: assert property (@(posedge mclk_out) disable iff (!rst_ext_n)
    en_ext |=> !src_is_pll);
endmodule

// File: tb/mclk_failover_sel_bench.sv
`timescale 1ns/1ps
module mclk_failover_sel_bench;
  localparam int HOLD = 40;
  localparam int SETTLE = 16;

  logic clk_ext = 0, clk_pll = 0;
  logic rst_ext_n = 0, rst_pll_n = 0;
  logic pll_locked = 0, lock_force = 0;
  logic [1:0] mode = 2'b10;
  logic mclk_out, src_is_pll;

  int compared = 0, mismatched = 0;

  always #2.5 clk_ext = ~clk_ext;   // 200 MHz
  always #4.0 clk_pll = ~clk_pll;

  mclk_failover_sel #(.HOLD_CYC(HOLD)) u_mclk_failover_sel (
    .clk_ext(clk_ext), .rst_ext_n(rst_ext_n), .clk_pll(clk_pll), .rst_pll_n(rst_pll_n),
    .pll_locked(pll_locked), .lock_force(lock_force), .mode(mode),
    .mclk_out(mclk_out), .src_is_pll(src_is_pll)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: sync queue, integer hold count, expected source
  int q_sync[$] = '{0, 0};
  int hold = 0;
  int exp_pll = 0;
  int stable = 0;
  always @(posedge clk_ext) begin
    if (rst_ext_n) begin
      int ls, ok, nxt;
      ls = q_sync[1];
      ok = (lock_force || (ls && hold == HOLD)) ? 1 : 0;
      if (mode == 2'b00)      nxt = 0;
      else if (mode == 2'b01) nxt = 1;
      else                    nxt = ok;
      if (!ls) hold = 0; else if (hold < HOLD) hold++;
      q_sync.pop_back();
      q_sync.push_front(pll_locked ? 1 : 0);
      stable = (nxt == exp_pll) ? stable + 1 : 0;
      exp_pll = nxt;
    end
  end

  function automatic string tag_now();
    if (mode == 2'b00) return "R1/R7";
    if (mode == 2'b01) return "R2/R7";
    if (lock_force)    return "R5/R7";
    return "R3/R4/R7";
  endfunction

  // compared on every clock once the expected source has been steady
  always @(negedge clk_ext) begin
    if (rst_ext_n && stable >= SETTLE)
      check(tag_now(), src_is_pll, exp_pll[0]);
  end

  // R6: pulse-width monitor on the output
  realtime t_last = 0;
  logic mon_on = 0;
  always @(mclk_out) begin
    if (mon_on) begin
      realtime w;
      w = $realtime - t_last;
      if (mclk_out == 1'b0) begin
        compared++;
        if (!((w > 2.49 && w < 2.51) || (w > 3.99 && w < 4.01))) begin
          mismatched++;
          $display("FAIL R6 high width actual=%0.3f expected=2.5 or 4.0", w);
        end
      end else begin
        compared++;
        if (w < 2.49) begin
          mismatched++;
          $display("FAIL R6 low width actual=%0.3f expected>=2.5", w);
        end
      end
    end
    t_last = $realtime;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_ext);
  endtask

  initial begin : watchdog
    #500000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    run(4);
    // R8: reset state
    check("R8 mclk_out in reset", mclk_out, 1'b0);
    check("R8 src_is_pll in reset", src_is_pll, 1'b0);
    @(negedge clk_ext);
    rst_ext_n = 1; rst_pll_n = 1;
    mon_on = 1;
    // automatic, lock absent: oscillator
    run(60);
    // clean lock return, switch after hold window (R4)
    pll_locked = 1;
    run(120);
    // clean loss (R3)
    pll_locked = 0;
    run(60);
    // chatter inside the hold window restarts the count (R4)
    for (int i = 0; i < 5; i++) begin
      pll_locked = 1; run(25);
      pll_locked = 0; run(3);
    end
    pll_locked = 1;
    run(120);
    // fixed oscillator, lock toggling ignored (R1)
    mode = 2'b00;
    run(60);
    pll_locked = 0; run(40);
    pll_locked = 1; run(40);
    // fixed PLL, lock toggling ignored (R2)
    mode = 2'b01;
    pll_locked = 0;
    run(80);
    pll_locked = 1; run(40);
    // back to automatic with force-lock and no lock (R5)
    mode = 2'b11;
    lock_force = 1;
    pll_locked = 0;
    run(100);
    // release force: falls back (R3)
    lock_force = 0;
    run(80);
    pll_locked = 1;
    run(120);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule